// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer. It produces one output pulse for every N = B·P + A cycles of its fast input clock. P is the lower modulus of a dual-modulus prescaler that divides by either P or P+1. B is the main count and A is the swallow count. While the swallow counter is still nonzero, it holds the prescaler at P+1. Once it reaches zero, the prescaler falls back to P. Both counters step down once per prescaler cycle. The whole ratio restarts when the main counter runs out.

The prescaler is a synchronous divide-by-4/5 core followed by one, two or three divide-by-2 stages. A two-bit select code picks how many stages are active, which gives moduli of 8/9, 16/17 or 32/33. The select code and the B and A values are captured into shadow registers at reset and at each output boundary, so a new setting never disturbs a ratio that is already running. An error flag reports active settings that cannot give a contiguous range of ratios. The divider keeps running even while the flag is raised.

Top module: `pulse_swallow_div`

## Requirements
- R1: For any setting with B ≥ 1 and A ≤ B, consecutive `div_pulse` rises are exactly B·P + A clock cycles apart. The first pulse appears B·P + A cycles after the last clock edge that sees `rst` high.
- R2: `div_pulse` is high for exactly one clock cycle per output period.
- R3: `psel` selects the lower modulus P as follows: 0 gives P=8, 1 gives P=16 and 2 gives P=32. Code 3 is reserved: it divides as P=8 and raises `cfg_err`.
- R4: A single prescaler cycle lasts P clocks when the swallow count is zero and P+1 clocks when it is nonzero, for each of the three moduli. With B=1, the period is P+A for A in {0,1}.
- R5: With A=0, every prescaler cycle uses modulus P, and the period is exactly B·P.
- R6: The swallow count starts at A and decreases by one per prescaler cycle until it reaches zero. The main count starts at B and decreases by one per prescaler cycle. Neither count changes between prescaler cycle ends.
- R7: A change of `psel`, `b_set` or `a_set` has no effect on the period in progress. The change takes effect from the clock edge that produces the next `div_pulse`, including a change applied in the very last cycle before that edge.
- R8: `cfg_err` is 1 exactly when the active settings satisfy at least one of these conditions: B < 3, A > B, A > P, B·P + A < P² − P, or `psel` = 3. It changes only at reset and at output boundaries, and it changes in the same cycle that `div_pulse` rises.
- R9: While `rst` is high, `div_pulse` is 0 and the inputs are captured as the active settings.
- R10: The largest setting reachable in the test window (P=8, B=8191, A=8) gives a first pulse 65536 cycles after reset. This shows that the 13-bit main count does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock to be divided |
| rst | input | 1 | Synchronous reset, active high; captures settings |
| psel | input | 2 | Prescaler modulus select code |
| b_set | input | B_W (13) | Main count preset B |
| a_set | input | A_W (5) | Swallow count preset A |
| div_pulse | output | 1 | One-cycle divided output pulse |
| cfg_err | output | 1 | Active settings are invalid or non-contiguous |

## Verification
The counter reload at terminal count and the capture of new settings into the shadow registers happen in the same cycle. The flag update also falls on the edge that produces `div_pulse`. The bench provokes this by changing `psel`, `b_set` and `a_set` in the final cycle of a period, to a setting that is invalid. It then judges three things: the ending period still has the old length, `cfg_err` rises together with that pulse, and the next interval has the new length. A second scenario changes the inputs in the middle of a period, to show that the period in progress is left alone.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  // Number of divide-by-2 stages behind the 4/5 core for a select code.
  function automatic int unsigned ext_stages(input logic [1:0] sel);
    case (sel)
      2'd1:    return 2;
      2'd2:    return 3;
      default: return 1;
    endcase
  endfunction

  // Lower modulus P of the dual-modulus prescaler.
  function automatic int unsigned low_modulus(input logic [1:0] sel);
    return 32'd4 << ext_stages(sel);
  endfunction

  // Total ratio N = B*P + A.
  function automatic int unsigned total_ratio(input int unsigned b,
                                              input int unsigned a,
                                              input int unsigned p);
    return b * p + a;
  endfunction

  // Setting that cannot be guaranteed contiguous or is out of range.
  function automatic logic settings_bad(input logic [1:0] sel,
                                        input int unsigned b,
                                        input int unsigned a);
    int unsigned p;
    int unsigned n;
    p = low_modulus(sel);
    n = total_ratio(b, a, p);
    return (sel == 2'd3) || (b < 3) || (a > b) || (a > p) || (n < p * p - p);
  endfunction

endpackage

// File: rtl/pswd_shadow.sv
module pswd_shadow #(
  parameter int B_W = 13,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [1:0]     psel,
  input  logic [B_W-1:0] b_set,
  input  logic [A_W-1:0] a_set,
  output logic [1:0]     sel_q,
  output logic           err
);
  logic [B_W-1:0] b_q;
  logic [A_W-1:0] a_q;

  always_ff @(posedge clk) begin
    if (load) begin
      sel_q <= psel;
      b_q   <= b_set;
      a_q   <= a_set;
    end
  end

  assign err = pswd_pkg::settings_bad(sel_q, 32'(b_q), 32'(a_q));

  // R7: active settings move only at a load
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(sel_q) && $stable(b_q) && $stable(a_q)));

endmodule

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int EXT_MAX = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_q,
  input  logic       mc,
  output logic       pre_tick
);
  localparam int E_W = EXT_MAX;

  logic [2:0]     core_cnt;
  logic           core_end;
  logic           swallow_now;
  logic           ext_full;
  logic [E_W-1:0] ext_q;
  logic [E_W-1:0] ext_act;
  logic [E_W:0]   full_upto;
  int unsigned    n_stages;

  assign n_stages     = pswd_pkg::ext_stages(sel_q);
  assign full_upto[0] = 1'b1;

  generate
    for (genvar i = 0; i < E_W; i++) begin : g_stage
      assign ext_act[i]     = (n_stages > i);
      assign full_upto[i+1] = full_upto[i] & (ext_q[i] | ~ext_act[i]);

      always_ff @(posedge clk) begin
        if (rst) begin
          ext_q[i] <= 1'b0;
        end else if (core_end) begin
          if (pre_tick)
            ext_q[i] <= 1'b0;
          else if (ext_act[i] && full_upto[i])
            ext_q[i] <= ~ext_q[i];
        end
      end
    end
  endgenerate

  assign ext_full    = full_upto[E_W];
  assign swallow_now = mc & ext_full;
  assign core_end    = (core_cnt == (swallow_now ? 3'd4 : 3'd3));
  assign pre_tick    = core_end & ext_full;

  always_ff @(posedge clk) begin
    if (rst)
      core_cnt <= 3'd0;
    else if (core_end)
      core_cnt <= 3'd0;
    else
      core_cnt <= core_cnt + 3'd1;
  end

  // R4: the 4/5 core never counts past its fifth state
  p_core_range_r4: assert property (@(posedge clk) disable iff (rst)
    core_cnt <= 3'd4);

  // R6: the fifth core state only occurs while the swallow line is active
  p_fifth_needs_mc_r6: assert property (@(posedge clk) disable iff (rst)
    (core_cnt == 3'd4) |-> mc);

endmodule

// File: rtl/pswd_swallow.sv
module pswd_swallow #(
  parameter int B_W = 13,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tick,
  input  logic [B_W-1:0] b_set,
  input  logic [A_W-1:0] a_set,
  output logic           mc,
  output logic           boundary
);
  logic [B_W-1:0] b_cnt;
  logic [A_W-1:0] a_cnt;
  logic           b_last;

  assign b_last   = (b_cnt <= B_W'(1));
  assign boundary = pre_tick & b_last;
  assign mc       = (a_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_cnt <= b_set;
      a_cnt <= a_set;
    end else if (pre_tick) begin
      if (b_last) begin
        b_cnt <= b_set;
        a_cnt <= a_set;
      end else begin
        b_cnt <= b_cnt - B_W'(1);
        if (a_cnt != '0)
          a_cnt <= a_cnt - A_W'(1);
      end
    end
  end

  // R6: both counts hold between prescaler cycle ends
  p_counts_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !pre_tick |=> ($stable(a_cnt) && $stable(b_cnt)));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int B_W     = 13,
  parameter int A_W     = 5,
  parameter int EXT_MAX = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     psel,
  input  logic [B_W-1:0] b_set,
  input  logic [A_W-1:0] a_set,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic [1:0] sel_q;
  logic       pre_tick;
  logic       mc;
  logic       boundary;
  logic       shadow_load;

  assign shadow_load = rst | boundary;

  pswd_shadow #(.B_W(B_W), .A_W(A_W)) i_shadow (
    .clk(clk), .rst(rst), .load(shadow_load),
    .psel(psel), .b_set(b_set), .a_set(a_set),
    .sel_q(sel_q), .err(cfg_err)
  );

  pswd_prescaler #(.EXT_MAX(EXT_MAX)) i_prescaler (
    .clk(clk), .rst(rst), .sel_q(sel_q), .mc(mc), .pre_tick(pre_tick)
  );

  pswd_swallow #(.B_W(B_W), .A_W(A_W)) i_swallow (
    .clk(clk), .rst(rst), .pre_tick(pre_tick),
    .b_set(b_set), .a_set(a_set), .mc(mc), .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (rst)
      div_pulse <= 1'b0;
    else
      div_pulse <= boundary;
  end

  // R2: output pulse is a single cycle wide
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R8: the error flag moves only at an output boundary
  p_err_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(cfg_err));

  // R9: no output pulse while reset is applied
  p_quiet_in_reset_r9: assert property (@(posedge clk)
    rst |=> !div_pulse);

endmodule

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic        clk   = 1'b0;
  logic        rst   = 1'b1;
  logic [1:0]  psel  = 2'd0;
  logic [12:0] b_set = 13'd10;
  logic [4:0]  a_set = 5'd3;
  logic        div_pulse;
  logic        cfg_err;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_div i_pulse_swallow_div (
    .clk(clk), .rst(rst), .psel(psel), .b_set(b_set), .a_set(a_set),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WD_LIMIT) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int ref_p(int sel);
    if (sel == 2) return 32;
    if (sel == 1) return 16;
    return 8;
  endfunction

  function automatic int ref_n(int sel, int b, int a);
    return ref_p(sel) * b + a;
  endfunction

  function automatic int ref_bad(int sel, int b, int a);
    int p;
    p = ref_p(sel);
    if (sel == 3 || b < 3 || a > b || a > p) return 1;
    if (ref_n(sel, b, a) < p * (p - 1)) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setv(input int sel, input int b, input int a);
    psel  = sel[1:0];
    b_set = b[12:0];
    a_set = a[4:0];
  endtask

  task automatic restart();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pulse(output int n, output int low_after);
    n = 0;
    low_after = 1;
    do begin
      @(negedge clk);
      n = n + 1;
      if (n == 1 && div_pulse) low_after = 0;
    end while (!div_pulse && n < 70000);
  endtask

  task automatic t_reset_state();
    int n, lo;
    setv(0, 10, 3);
    restart();
    wait_pulse(n, lo);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 pulse low in reset", div_pulse, 0);
    setv(1, 20, 0);
    @(negedge clk);
    chk("R9 pulse low in reset held", div_pulse, 0);
    rst = 1'b0;
    chk("R9 settings captured in reset", cfg_err, ref_bad(1, 20, 0));
    wait_pulse(n, lo);
    chk("R9 first period uses captured settings", n, ref_n(1, 20, 0));
  endtask

  task automatic t_basic();
    int n, lo;
    setv(0, 10, 3);
    restart();
    wait_pulse(n, lo);
    chk("R1 first latency", n, ref_n(0, 10, 3));
    chk("R8 valid setting no error", cfg_err, 0);
    wait_pulse(n, lo);
    chk("R1 steady interval", n, 83);
    chk("R2 pulse one cycle wide", lo, 1);
    wait_pulse(n, lo);
    chk("R6 swallow counts then stops", n, 83);
  endtask

  task automatic t_a_zero();
    int n, lo;
    setv(1, 20, 0);
    restart();
    wait_pulse(n, lo);
    chk("R5 A zero latency", n, 320);
    wait_pulse(n, lo);
    chk("R5 A zero interval", n, 320);
  endtask

  task automatic t_wide();
    int n, lo;
    setv(2, 40, 17);
    restart();
    wait_pulse(n, lo);
    wait_pulse(n, lo);
    chk("R3 code 2 gives P=32", n, ref_n(2, 40, 17));
    chk("R8 P=32 valid no error", cfg_err, 0);
    setv(0, 9, 8);
    restart();
    wait_pulse(n, lo);
    chk("R6 A equal P", n, 80);
    chk("R8 A equal P accepted", cfg_err, 0);
  endtask

  task automatic t_single_cycle();
    int n, lo;
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 2; a++) begin
        setv(s, 1, a);
        restart();
        wait_pulse(n, lo);
        chk("R4 one prescaler cycle", n, ref_p(s) + a);
      end
    end
  endtask

  task automatic t_reserved();
    int n, lo;
    setv(3, 10, 3);
    restart();
    chk("R3 reserved code flagged", cfg_err, 1);
    wait_pulse(n, lo);
    chk("R3 reserved code divides as P=8", n, 83);
  endtask

  task automatic t_errors();
    int cs [6][3] = '{'{0, 2, 0}, '{0, 7, 8}, '{0, 20, 9},
                      '{1, 10, 0}, '{1, 15, 0}, '{0, 3, 0}};
    for (int i = 0; i < 6; i++) begin
      setv(cs[i][0], cs[i][1], cs[i][2]);
      restart();
      chk("R8 error flag", cfg_err, ref_bad(cs[i][0], cs[i][1], cs[i][2]));
    end
  endtask

  task automatic t_midchange();
    int n, lo;
    setv(0, 10, 3);
    restart();
    wait_pulse(n, lo);
    repeat (20) @(negedge clk);
    setv(0, 12, 1);
    wait_pulse(n, lo);
    chk("R7 mid change ignored", n, 83 - 20);
    wait_pulse(n, lo);
    chk("R7 new setting after boundary", n, ref_n(0, 12, 1));
  endtask

  task automatic t_boundary_change();
    int n, lo;
    setv(0, 10, 3);
    restart();
    wait_pulse(n, lo);
    repeat (83 - 1) @(negedge clk);
    chk("R8 flag still clear before boundary", cfg_err, 0);
    setv(0, 2, 0);
    wait_pulse(n, lo);
    chk("R7 last cycle change keeps old period", n, 1);
    chk("R8 flag rises with pulse", cfg_err, 1);
    wait_pulse(n, lo);
    chk("R7 last cycle change applied next", n, 16);
  endtask

  task automatic t_max();
    int n, lo;
    setv(0, 8191, 8);
    restart();
    wait_pulse(n, lo);
    chk("R10 largest ratio latency", n, 65536);
  endtask

  initial begin
    t_reset_state();
    t_basic();
    t_a_zero();
    t_wide();
    t_single_cycle();
    t_reserved();
    t_errors();
    t_midchange();
    t_boundary_change();
    t_max();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule